// File: doc/BRIEF.md
# I2C Command-Echo Target

This block is an I2C target that collects one-byte command codes from a bus controller and answers them in a single read. In a write transfer the controller may send several command bytes. The block acknowledges each one and stores it in a small queue. The controller then issues a repeated START and reads. For every stored command, in the order it arrived, the block first echoes the command byte and then sends one result byte.

Local logic sees each command as a one-cycle strobe with the command byte. It answers in that same cycle on a result input, which the block captures at once. The bus side uses two synchronizing flops on SCL and SDA in the system clock domain. SDA is an open-drain line: the block only ever asserts a pull-low enable.

Top module: `cmdEchoTarget`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 0x12. For any other address, SDA stays released during the ninth clock.
- R2: While the queue has room, every written command byte is acknowledged. Acknowledging means the pull-low enable is high during the ninth SCL high period.
- R3: Several command bytes written in one transfer are all queued, and their arrival order is kept.
- R4: After a repeated START, an address byte of 0x12 with the read bit (bit 0) set is acknowledged.
- R5: During the read, each queued command is followed by its result byte. Pairs come out in arrival order, and every byte is sent most significant bit first.
- R6: Each dequeue gives a `cmdValid` pulse exactly one clock long, with the command on `cmdByte`. `resultByte` is captured only in that cycle.
- R7: When the controller does not acknowledge a returned byte, the block releases SDA. It drives nothing more until the next START.
- R8: The queue holds 8 commands. A command byte written while the queue is full is not acknowledged and is discarded.
- R9: If the controller acknowledges past the last queued pair, the block returns 0xFF bytes until it sees a not-acknowledge.
- R10: A STOP empties the queue, so a later read returns only 0xFF bytes.
- R11: A START followed by a non-matching address empties the queue and puts the block back to idle.
- R12: The SDA pull-low enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin |
| sdaOe | output | 1 | Pull-low enable for the data line (1 = drive low) |
| cmdValid | output | 1 | One-cycle strobe when a command is dequeued for echo |
| cmdByte | output | 8 | Command byte, valid while `cmdValid` is high |
| resultByte | input | 8 | Result for `cmdByte`, sampled while `cmdValid` is high |

## Verification
Three events can land in the same system cycle: the falling SCL edge that ends the controller's acknowledge, the dequeue that captures the local result, and the loading of the next transmit byte. When the queue runs dry, that same edge also switches the source to 0xFF. The bench drives `resultByte` with the correct answer only while the strobe is high and with zero otherwise, so a capture one cycle off shows up as a wrong data byte on the bus. It also acknowledges beyond the last pair, both after a full queue and after an empty one, and checks that the boundary byte and every later byte equal 0xFF.

// File: rtl/cmdEchoPkg.sv
package cmdEchoPkg;

  parameter int BYTE_W = 8;
  parameter int CNT_W  = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
    logic loadCmd;
    logic loadRes;
    logic shiftTx;
    logic clrCnt;
  } dpCtrl_t;

  // Bus events decoded by the datapath
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startSeen;
    logic stopSeen;
    logic sclHigh;
  } busEv_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_TX,
    ST_TX_ACK
  } ctlState_t;

endpackage

// File: rtl/cmdEchoDatapath.sv
module cmdEchoDatapath
  import cmdEchoPkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCtrl_t           ctl,
  input  logic [BYTE_W-1:0] resultByte,
  output busEv_t            ev,
  output logic              sdaNow,
  output logic [CNT_W-1:0]  bitCnt,
  output logic [BYTE_W-1:0] rxByte,
  output logic [BYTE_W-1:0] headByte,
  output logic              fifoFull,
  output logic              fifoEmpty,
  output logic              txMsb
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  // Two-flop synchronizers plus one history flop each
  logic [1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev;
  logic sclS, sdaS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  assign sclS = sclSync[1];
  assign sdaS = sdaSync[1];
  assign sdaNow = sdaS;

  always_comb begin
    ev.sclRise   = sclS & ~sclPrev;
    ev.sclFall   = ~sclS & sclPrev;
    ev.startSeen = sclS & sclPrev & sdaPrev & ~sdaS;
    ev.stopSeen  = sclS & sclPrev & ~sdaPrev & sdaS;
    ev.sclHigh   = sclS;
  end

  // Bit counter and receive shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      rxByte <= '0;
    end else begin
      if (ctl.clrCnt) begin
        bitCnt <= '0;
      end else if (ev.sclRise && bitCnt != {CNT_W{1'b1}}) begin
        bitCnt <= bitCnt + 1'b1;
      end
      if (ev.sclRise) begin
        rxByte <= {rxByte[BYTE_W-2:0], sdaS};
      end
    end
  end

  // Command queue
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] cnt;

  assign fifoFull  = (cnt == FULL_CNT);
  assign fifoEmpty = (cnt == '0);
  assign headByte  = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (ctl.push) begin
      mem[wrPtr] <= rxByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else if (ctl.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      if (ctl.push) begin
        wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      end
      if (ctl.pop) begin
        rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      end
      case ({ctl.push, ctl.pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // Transmit shifter and captured result
  logic [BYTE_W-1:0] txShift, resReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '1;
      resReg  <= '1;
    end else if (ctl.loadCmd) begin
      txShift <= ctl.pop ? headByte : '1;
      resReg  <= ctl.pop ? resultByte : '1;
    end else if (ctl.loadRes) begin
      txShift <= resReg;
    end else if (ctl.shiftTx) begin
      txShift <= {txShift[BYTE_W-2:0], 1'b1};
    end
  end

  assign txMsb = txShift[BYTE_W-1];

  // R10
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.flush |=> fifoEmpty);

  // R8
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= FULL_CNT);

  // R3
  push_lands_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.push && !ctl.flush) |=> !fifoEmpty);

endmodule

// File: rtl/cmdEchoControl.sv
module cmdEchoControl
  import cmdEchoPkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h12
) (
  input  logic              clk,
  input  logic              rstN,
  input  busEv_t            ev,
  input  logic              sdaNow,
  input  logic [CNT_W-1:0]  bitCnt,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              fifoFull,
  input  logic              fifoEmpty,
  input  logic              txMsb,
  output dpCtrl_t           ctl,
  output logic              sdaOe
);

  localparam logic [CNT_W-1:0] FULL_BYTE = CNT_W'(BYTE_W);

  ctlState_t state, nxt;
  logic ackDrive, rdMode, resNext, masterAck;
  logic byteDone;

  assign byteDone = ev.sclFall && (bitCnt == FULL_BYTE);

  always_comb begin
    nxt = state;
    ctl = '0;
    if (ev.stopSeen) begin
      nxt = ST_IDLE;
      ctl.flush = 1'b1;
    end else if (ev.startSeen) begin
      nxt = ST_ADDR;
      ctl.clrCnt = 1'b1;
    end else begin
      case (state)
        ST_ADDR: if (byteDone) begin
          if (rxByte[BYTE_W-1:1] == TARGET_ADDR) begin
            nxt = ST_ADDR_ACK;
          end else begin
            nxt = ST_IDLE;
            ctl.flush = 1'b1;
          end
        end
        ST_ADDR_ACK: if (ev.sclFall) begin
          ctl.clrCnt = 1'b1;
          if (rdMode) begin
            nxt = ST_TX;
            ctl.loadCmd = 1'b1;
            ctl.pop = !fifoEmpty;
          end else begin
            nxt = ST_WDATA;
          end
        end
        ST_WDATA: if (byteDone) begin
          nxt = ST_WDATA_ACK;
          ctl.push = !fifoFull;
        end
        ST_WDATA_ACK: if (ev.sclFall) begin
          nxt = ST_WDATA;
          ctl.clrCnt = 1'b1;
        end
        ST_TX: if (ev.sclFall) begin
          if (bitCnt == FULL_BYTE) begin
            nxt = ST_TX_ACK;
          end else begin
            ctl.shiftTx = 1'b1;
          end
        end
        ST_TX_ACK: if (ev.sclFall) begin
          if (masterAck) begin
            nxt = ST_TX;
            ctl.clrCnt = 1'b1;
            if (resNext) begin
              ctl.loadRes = 1'b1;
            end else begin
              ctl.loadCmd = 1'b1;
              ctl.pop = !fifoEmpty;
            end
          end else begin
            nxt = ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      ackDrive  <= 1'b0;
      rdMode    <= 1'b0;
      resNext   <= 1'b0;
      masterAck <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_ADDR && nxt == ST_ADDR_ACK) begin
        ackDrive <= 1'b1;
        rdMode   <= rxByte[0];
      end else if (state == ST_WDATA && nxt == ST_WDATA_ACK) begin
        ackDrive <= ctl.push;
      end else if (nxt != ST_ADDR_ACK && nxt != ST_WDATA_ACK) begin
        ackDrive <= 1'b0;
      end
      if (ctl.loadCmd) begin
        resNext <= 1'b1;
      end else if (ctl.loadRes) begin
        resNext <= 1'b0;
      end
      if (state == ST_TX_ACK && ev.sclRise) begin
        masterAck <= !sdaNow;
      end
    end
  end

  always_comb begin
    case (state)
      ST_ADDR_ACK, ST_WDATA_ACK: sdaOe = ackDrive;
      ST_TX:                     sdaOe = !txMsb;
      default:                   sdaOe = 1'b0;
    endcase
  end

  // R12
  sda_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ev.sclHigh && $past(ev.sclHigh)) |-> $stable(sdaOe));

  // R6
  pop_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pop |-> !ev.sclHigh);

  // R7
  nak_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_TX_ACK && ev.sclFall && !masterAck && !ev.startSeen) |=> !sdaOe);

endmodule

// File: rtl/cmdEchoTarget.sv
module cmdEchoTarget
  import cmdEchoPkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h12,
  parameter int         DEPTH       = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaOe,
  output logic              cmdValid,
  output logic [BYTE_W-1:0] cmdByte,
  input  logic [BYTE_W-1:0] resultByte
);

  dpCtrl_t           ctl;
  busEv_t            ev;
  logic              sdaNow, fifoFull, fifoEmpty, txMsb;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] rxByte, headByte;

  cmdEchoDatapath #(.DEPTH(DEPTH)) dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .ctl(ctl), .resultByte(resultByte), .ev(ev), .sdaNow(sdaNow),
    .bitCnt(bitCnt), .rxByte(rxByte), .headByte(headByte),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .txMsb(txMsb)
  );

  cmdEchoControl #(.TARGET_ADDR(TARGET_ADDR)) ctrl (
    .clk(clk), .rstN(rstN), .ev(ev), .sdaNow(sdaNow), .bitCnt(bitCnt),
    .rxByte(rxByte), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .txMsb(txMsb), .ctl(ctl), .sdaOe(sdaOe)
  );

  assign cmdValid = ctl.pop;
  assign cmdByte  = headByte;

endmodule

// File: tb/cmdEchoTarget_test.sv
`timescale 1ns/1ps
module cmdEchoTarget_test;

  localparam int Q = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclIn = 1'b1;
  logic ctrlSda = 1'b1;
  logic sdaOe, cmdValid;
  logic [7:0] cmdByte, resultByte;
  wire busSda = ctrlSda & ~sdaOe;

  int checks = 0;
  int bad = 0;
  int viol = 0;
  int dblStrobe = 0;
  int capN = 0;
  logic [7:0] capLog [256];
  logic [7:0] cmdBuf [16];
  logic [7:0] expBuf [40];

  always #2.5 clk = ~clk;

  function automatic logic [7:0] resFn(input logic [7:0] c);
    return {c[2:0], c[7:3]} ^ 8'h3C;
  endfunction

  // local side answers only while the strobe is high
  assign resultByte = cmdValid ? resFn(cmdByte) : 8'h00;

  cmdEchoTarget uut (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(busSda), .sdaOe(sdaOe),
    .cmdValid(cmdValid), .cmdByte(cmdByte), .resultByte(resultByte)
  );

  logic prevScl = 1'b1, prevOe = 1'b0, prevV = 1'b0;
  always @(negedge clk) begin
    if (sclIn && prevScl && sdaOe != prevOe) viol++;
    if (cmdValid) begin
      if (prevV) dblStrobe++;
      capLog[capN[7:0]] = cmdByte;
      capN++;
    end
    prevScl = sclIn;
    prevOe  = sdaOe;
    prevV   = cmdValid;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic busStart();
    ctrlSda = 1'b1; waitQ();
    sclIn = 1'b1;   waitQ();
    ctrlSda = 1'b0; waitQ();
    sclIn = 1'b0;   waitQ();
  endtask

  task automatic busStop();
    ctrlSda = 1'b0; waitQ();
    sclIn = 1'b1;   waitQ();
    ctrlSda = 1'b1; waitQ(); waitQ();
  endtask

  task automatic sendBit(input logic b);
    ctrlSda = b; waitQ();
    sclIn = 1'b1; waitQ(); waitQ();
    sclIn = 1'b0; waitQ();
  endtask

  task automatic readBit(output logic b);
    ctrlSda = 1'b1; waitQ();
    sclIn = 1'b1; waitQ();
    b = busSda; waitQ();
    sclIn = 1'b0; waitQ();
  endtask

  task automatic writeByte(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    readBit(b);
    ack = !b;
  endtask

  task automatic readByte(output logic [7:0] v, input logic nak);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      readBit(b);
      v[i] = b;
    end
    sendBit(nak);
  endtask

  // address already sent; writes cmdBuf[0..n-1], queue assumed empty
  task automatic writeCmds(input int n);
    logic a;
    for (int i = 0; i < n; i++) begin
      writeByte(cmdBuf[i], a);
      if (i < 8) chk("R2 command ack", a, 1);
      else       chk("R8 full queue nak", a, 0);
    end
  endtask

  // repeated START + read address, then nPairs pairs and nTail 0xFF bytes
  task automatic readBack(input int nPairs, input int nTail, input string tailTag);
    logic a;
    logic [7:0] v;
    int total;
    int base;
    total = 2 * nPairs + nTail;
    base = capN;
    for (int i = 0; i < nPairs; i++) begin
      expBuf[2*i]   = cmdBuf[i];
      expBuf[2*i+1] = resFn(cmdBuf[i]);
    end
    busStart();
    writeByte({7'h12, 1'b1}, a);
    chk("R4 read address ack", a, 1);
    for (int i = 0; i < total; i++) begin
      readByte(v, i == total - 1);
      if (i < 2 * nPairs) chk("R5 echo byte", v, expBuf[i]);
      else                chk(tailTag, v, 8'hFF);
    end
    chk("R6 strobe count", capN - base, nPairs);
    for (int i = 0; i < nPairs; i++)
      chk("R6 strobe command", capLog[(base + i) % 256], cmdBuf[i]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", checks + 1, bad);
    $finish;
  end

  initial begin
    logic a;
    logic b;
    int ones;
    int n;
    void'($urandom(32'd20240611));
    repeat (8) @(posedge clk);
    #1 rstN = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R12 reset sdaOe", sdaOe, 0);
    chk("R6 reset cmdValid", cmdValid, 0);

    // R1: foreign address ignored
    busStart();
    writeByte({7'h13, 1'b0}, a);
    chk("R1 foreign address nak", a, 0);
    busStop();

    // R3 / R5: three commands, echoed in order
    cmdBuf[0] = 8'hA1; cmdBuf[1] = 8'h00; cmdBuf[2] = 8'h7E;
    busStart();
    writeByte({7'h12, 1'b0}, a);
    chk("R1 own address ack", a, 1);
    writeCmds(3);
    readBack(3, 0, "R9");
    busStop();

    // R8 and R9: overfill, then acknowledge past the end
    for (int i = 0; i < 9; i++) cmdBuf[i] = 8'(8'h30 + 8'(i * 17));
    busStart();
    writeByte({7'h12, 1'b0}, a);
    writeCmds(9);
    readBack(8, 2, "R9 tail byte");
    busStop();

    // R10: STOP flushes pending commands
    cmdBuf[0] = 8'h11; cmdBuf[1] = 8'h22; cmdBuf[2] = 8'h33;
    busStart();
    writeByte({7'h12, 1'b0}, a);
    writeCmds(3);
    busStop();
    readBack(0, 2, "R10 flushed by stop");
    busStop();

    // R11: START with foreign address flushes
    cmdBuf[0] = 8'h44; cmdBuf[1] = 8'h55;
    busStart();
    writeByte({7'h12, 1'b0}, a);
    writeCmds(2);
    busStart();
    writeByte({7'h34, 1'b1}, a);
    chk("R11 foreign address nak", a, 0);
    readBack(0, 2, "R11 flushed by foreign start");
    busStop();

    // R7: after NAK the block leaves SDA alone
    cmdBuf[0] = 8'h00;
    busStart();
    writeByte({7'h12, 1'b0}, a);
    writeCmds(1);
    readBack(1, 0, "R9");
    ones = 0;
    for (int i = 0; i < 9; i++) begin
      readBit(b);
      ones += int'(b);
    end
    chk("R7 released after nak", ones, 9);
    busStop();

    // random batches
    for (int it = 0; it < 10; it++) begin
      n = $urandom_range(1, 8);
      for (int i = 0; i < n; i++) cmdBuf[i] = 8'($urandom);
      busStart();
      writeByte({7'h12, 1'b0}, a);
      chk("R1 own address ack", a, 1);
      writeCmds(n);
      readBack(n, 2 * $urandom_range(0, 1), "R9 random tail");
      busStop();
    end

    chk("R12 sda change while scl high", viol, 0);
    chk("R6 back-to-back strobe", dblStrobe, 0);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule